// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a finite impulse response filter with no multipliers. Each accepted input sample is pushed into a tap delay line that holds exactly one sample per coefficient. The output for that sample is then built over one clock cycle per sample bit. In each of those cycles the block takes the same bit position from every stored sample, least significant bit first. These bits address small precomputed tables that hold the partial sums of the coefficients. The table outputs are added, and the total is merged into an accumulator that shifts right by one bit every cycle.

The coefficients are fixed at elaboration through a packed parameter. The tables are generated from that parameter, one table per group of taps. A producer presents samples with a valid/ready handshake, and a consumer takes results from a registered output qualified by a one-cycle valid pulse. A result is ready `SAMPLE_W` cycles after its sample is accepted. A new sample can be accepted in the same cycle that the previous result is presented.

Top module: `dafir_top`

## Requirements
- R1: The delay line holds NUM_TAPS samples. The newest accepted sample is tap 0, and the sample accepted k samples earlier is weighted by coefficient k, which sits at bits [k*COEF_W +: COEF_W] of COEFS. The line changes only when a sample is accepted.
- R2: The result for the newest sample n is y = sum over k of c[k]*x[n-k], exact in two's complement, and outData equals y arithmetically shifted right by (SAMPLE_W+COEF_W+log2(NUM_TAPS)-OUT_W).
- R3: The taps are split into groups of PART_TAPS. Each group has a 2^PART_TAPS-entry table, and entry a holds the sum of that group's coefficients whose address bit in a is set. The group outputs are added before accumulation.
- R4: Samples are SAMPLE_W-bit two's complement and are processed least significant bit first. On the sign-bit cycle the table sum is subtracted, so the most negative sample value is filtered exactly.
- R5: inReady is high only while no result is being computed. A sample is taken when inValid and inReady are both high. Values presented while inReady is low are ignored.
- R6: outValid is a single-cycle pulse that rises on the SAMPLE_W-th rising clock edge after the accepting edge. In that same cycle inReady is high again, so a new sample can be accepted.
- R7: Synchronous reset clears the delay line and the accumulator, deasserts outValid and leaves inReady high. It also abandons a result that is in progress.
- R8: outData holds its value between outValid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample offered |
| inReady | output | 1 | Filter can take a sample |
| inData | input | SAMPLE_W | Two's complement input sample |
| outValid | output | 1 | One-cycle pulse marking a new result |
| outData | output | OUT_W | Filter result, upper OUT_W bits of the exact sum |

## Verification
Two events can fall in the same cycle: a finished result is presented, and the next sample is accepted into the delay line. The stimulus keeps inValid high from one sample to the next, so every acceptance after the first lands in the cycle that carries outValid. The scoreboard then checks that the presented value was computed from the old delay-line contents. It also checks that the following result includes the sample taken in that cycle. Junk data is driven while inReady is low, to show that only the handshake cycle captures a sample.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  // Strobes issued by the sequencer to the arithmetic datapath
  typedef struct packed {
    logic loadSample;  // shift new sample in, clear accumulator
    logic accumStep;   // one bit-slice accumulation cycle
    logic signStep;    // current slice is the sign bit: subtract
    logic outLatch;    // capture the finished sum into the output
  } daStrobes_t;

endpackage

// File: rtl/dafir_lut.sv
module dafir_lut #(
  parameter int PART_TAPS = 4,
  parameter int COEF_W    = 10,
  parameter int SUM_W     = 14,
  parameter logic [PART_TAPS*COEF_W-1:0] PART_COEFS = '0
) (
  input  logic [PART_TAPS-1:0]     addr,
  output logic signed [SUM_W-1:0]  sum
);

  localparam int DEPTH = 1 << PART_TAPS;

  // Sum of the group's coefficients selected by the bits of k
  function automatic logic signed [SUM_W-1:0] entryValue(input int k);
    logic signed [SUM_W-1:0] total;
    logic signed [COEF_W-1:0] coef;
    total = '0;
    for (int t = 0; t < PART_TAPS; t++) begin
      coef = signed'(PART_COEFS[t*COEF_W +: COEF_W]);
      if (k[t]) total = total + SUM_W'(coef);
    end
    return total;
  endfunction

  logic signed [SUM_W-1:0] entries [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    assign entries[k] = entryValue(k);
  end

  assign sum = entries[addr];

endmodule

// File: rtl/dafir_ctrl.sv
module dafir_ctrl
  import dafir_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  output daStrobes_t       strb,
  output logic [IDX_W-1:0] bitIdx,
  output logic             outValid
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t       state;
  logic [IDX_W-1:0] bitCnt;
  logic             lastBit;

  assign inReady = (state == ST_IDLE);
  assign lastBit = (bitCnt == IDX_W'(SAMPLE_W - 1));
  assign bitIdx  = bitCnt;

  always_comb begin
    strb            = '0;
    strb.loadSample = inReady && inValid;
    strb.accumStep  = (state == ST_RUN);
    strb.signStep   = (state == ST_RUN) && lastBit;
    strb.outLatch   = (state == ST_RUN) && lastBit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.outLatch;
      case (state)
        ST_IDLE: begin
          bitCnt <= '0;
          if (inValid) state <= ST_RUN;
        end
        ST_RUN: begin
          if (lastBit) begin
            state  <= ST_IDLE;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid); // R6

  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> inReady); // R6

endmodule

// File: rtl/dafir_datapath.sv
module dafir_datapath
  import dafir_pkg::*;
#(
  parameter int NUM_TAPS  = 8,
  parameter int PART_TAPS = 4,
  parameter int SAMPLE_W  = 8,
  parameter int COEF_W    = 10,
  parameter int OUT_W     = 18,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = '0,
  localparam int IDX_W     = $clog2(SAMPLE_W),
  localparam int TAP_LOG   = $clog2(NUM_TAPS),
  localparam int NUM_PARTS = NUM_TAPS / PART_TAPS,
  localparam int SUM_W     = COEF_W + TAP_LOG + 1,
  localparam int FULL_W    = SAMPLE_W + COEF_W + TAP_LOG,
  localparam int ACC_W     = FULL_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  daStrobes_t          strb,
  input  logic [IDX_W-1:0]    bitIdx,
  input  logic [SAMPLE_W-1:0] inData,
  output logic [OUT_W-1:0]    outData
);

  // Tap delay line, tap 0 newest
  logic [NUM_TAPS-1:0][SAMPLE_W-1:0] line;

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
    end else if (strb.loadSample) begin
      line[0] <= inData;
      for (int t = 1; t < NUM_TAPS; t++) line[t] <= line[t-1];
    end
  end

  // One bit position taken from every stored sample
  logic [NUM_TAPS-1:0] slice;

  always_comb begin
    for (int t = 0; t < NUM_TAPS; t++) slice[t] = line[t][bitIdx];
  end

  // Partition tables
  logic signed [SUM_W-1:0] partSum [NUM_PARTS];

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    dafir_lut #(
      .PART_TAPS (PART_TAPS),
      .COEF_W    (COEF_W),
      .SUM_W     (SUM_W),
      .PART_COEFS(COEFS[p*PART_TAPS*COEF_W +: PART_TAPS*COEF_W])
    ) u_lut (
      .addr(slice[p*PART_TAPS +: PART_TAPS]),
      .sum (partSum[p])
    );
  end

  logic signed [SUM_W-1:0] tableSum;

  always_comb begin
    tableSum = '0;
    for (int p = 0; p < NUM_PARTS; p++) tableSum = tableSum + partSum[p];
  end

  // Shift-accumulator: right shift each cycle, term weighted by 2^(SAMPLE_W-1)
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] accShifted;
  logic signed [ACC_W-1:0] termExt;
  logic signed [ACC_W-1:0] accNext;

  assign termExt    = {{(ACC_W-SUM_W){tableSum[SUM_W-1]}}, tableSum} <<< (SAMPLE_W - 1);
  assign accShifted = acc >>> 1;
  assign accNext    = strb.signStep ? (accShifted - termExt) : (accShifted + termExt);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      outData <= '0;
    end else begin
      if (strb.loadSample)     acc <= '0;
      else if (strb.accumStep) acc <= accNext;
      if (strb.outLatch) outData <= accNext[FULL_W-1 -: OUT_W];
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.loadSample |=> $stable(line)); // R1

  AST_LOAD_OR_STEP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadSample, strb.accumStep})); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    strb.outLatch |-> (accNext[ACC_W-1] == accNext[FULL_W-1])); // R2

endmodule

// File: rtl/dafir_top.sv
module dafir_top
  import dafir_pkg::*;
#(
  parameter int NUM_TAPS  = 8,
  parameter int PART_TAPS = 4,
  parameter int SAMPLE_W  = 8,
  parameter int COEF_W    = 10,
  parameter int OUT_W     = 18,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = {
    10'h005, 10'h200, 10'h040, 10'h0C8, 10'h0FF, 10'h065, 10'h3DB, 10'h00C}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inData,
  output logic                outValid,
  output logic [OUT_W-1:0]    outData
);

  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam int CNT_W = $clog2(SAMPLE_W + 2);

  daStrobes_t       strb;
  logic [IDX_W-1:0] bitIdx;

  dafir_ctrl #(
    .SAMPLE_W(SAMPLE_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inReady (inReady),
    .strb    (strb),
    .bitIdx  (bitIdx),
    .outValid(outValid)
  );

  dafir_datapath #(
    .NUM_TAPS (NUM_TAPS),
    .PART_TAPS(PART_TAPS),
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .OUT_W    (OUT_W),
    .COEFS    (COEFS)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .bitIdx (bitIdx),
    .inData (inData),
    .outData(outData)
  );

  // Edges since the last accepted sample, saturating; supports the cadence check
  logic [CNT_W-1:0] sinceAccept;

  always_ff @(posedge clk) begin
    if (rst)                          sinceAccept <= CNT_W'(SAMPLE_W + 1);
    else if (inValid && inReady)      sinceAccept <= '0;
    else if (sinceAccept != CNT_W'(SAMPLE_W + 1)) sinceAccept <= sinceAccept + 1'b1;
  end

  AST_RESULT_CADENCE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sinceAccept == CNT_W'(SAMPLE_W))); // R6

endmodule

// File: tb/dafir_top_tb.sv
`timescale 1ns/1ps
module dafir_top_tb;

  localparam int NT   = 8;
  localparam int PT   = 4;
  localparam int SW   = 8;
  localparam int CW   = 10;
  localparam int OW   = 18;
  localparam int FW   = SW + CW + $clog2(NT);
  localparam int DROP = FW - OW;
  localparam logic [NT*CW-1:0] COEFS_TB = {
    10'h005, 10'h200, 10'h040, 10'h0C8, 10'h0FF, 10'h065, 10'h3DB, 10'h00C};
  // Same values as integers, index = tap (R1 ordering)
  int coefTb [NT] = '{12, -37, 101, 255, 200, 64, -512, 5};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [SW-1:0] inData = '0;
  logic          outValid;
  logic [OW-1:0] outData;

  always #10 clk = ~clk;  // 50 MHz

  dafir_top #(
    .NUM_TAPS(NT), .PART_TAPS(PT), .SAMPLE_W(SW), .COEF_W(CW), .OUT_W(OW), .COEFS(COEFS_TB)
  ) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  int checks = 0;
  int fails  = 0;
  int cycleCnt = 0;
  int hist [NT];
  int expQ [$];
  int accQ [$];
  int lastSeen = 0;
  logic prevValid = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic checkEq(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (outValid && prevValid) checkEq("R6 pulse width", 1, 0);
      if (outValid) begin
        if (expQ.size() == 0) begin
          checkEq("R6 unexpected result", 1, 0);
        end else begin
          int e, a;
          e = expQ.pop_front();
          a = accQ.pop_front();
          checkEq("R2/R3/R4 result", int'($signed(outData)), e);
          checkEq("R6 latency", cycleCnt - a, SW + 1);
          checkEq("R6 ready with result", int'(inReady), 1);
          lastSeen = int'($signed(outData));
        end
      end
    end
    prevValid = outValid;
  end

  // Driver: called at a negedge, returns at the negedge after acceptance
  task automatic sendSample(input int x);
    int y;
    inValid = 1'b1;
    while (!inReady) begin
      inData = SW'($urandom);  // R5: ignored while busy
      @(negedge clk);
    end
    inData = SW'(x);
    begin
      int acc0;
      acc0 = cycleCnt;
      @(posedge clk);
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      y = 0;
      for (int k = 0; k < NT; k++) y += coefTb[k] * hist[k];
      expQ.push_back(y >>> DROP);
      accQ.push_back(acc0);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    inValid = 1'b0;
    expQ.delete();
    accQ.delete();
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    @(negedge clk);
    doReset();
    // R7: reset state
    checkEq("R7 ready after reset", int'(inReady), 1);
    checkEq("R7 valid after reset", int'(outValid), 0);

    // R1/R3: impulse reveals each coefficient in tap order (cleared line, R7)
    sendSample(100);
    for (int i = 0; i < NT; i++) sendSample(0);
    // R4: most negative sample as impulse
    sendSample(-128);
    for (int i = 0; i < NT; i++) sendSample(0);
    // Step of the largest positive value
    for (int i = 0; i < 10; i++) sendSample(127);
    // Step of the most negative value
    for (int i = 0; i < 10; i++) sendSample(-128);
    // Random, with the most negative value mixed in
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 3) sendSample(-128);
      else sendSample(int'($urandom_range(0, 255)) - 128);
    end
    drain();

    // R8: output holds while idle
    repeat (6) @(negedge clk);
    checkEq("R8 output hold", int'($signed(outData)), lastSeen);
    checkEq("R8 no spurious valid", int'(outValid), 0);

    // R7: reset mid-computation abandons the result and clears the line
    sendSample(90);
    sendSample(-77);
    @(negedge clk);
    doReset();
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < SW + 3; i++) begin
        if (outValid) seen++;
        @(negedge clk);
      end
      checkEq("R7 abandoned result", seen, 0);
    end
    sendSample(-128);
    sendSample(1);
    sendSample(0);
    drain();
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule